// File: doc/BRIEF.md
# DMA Physical Address Generator

This block turns a DMA channel's 16-bit current address counter into a 32-bit physical byte address for the memory bus. It serves eight channels split over two cascaded controllers. Channels 0 to 3 move single bytes inside 64K pages. Channels 5 to 7 move 16-bit words inside 128K pages. Channel 4 carries the link from the first controller into the second and never moves data.

Each channel has two page bytes. The low page byte supplies the address bits directly above the counter. The high page byte supplies bits 31:24. A write to the low page byte sets the high page byte back to zero, so software that only knows 24-bit addressing still gets correct addresses. Software that wants 32-bit addressing therefore writes the high page byte last.

For each request the block returns the address, a pair of byte enables, and a flag. The flag marks a counter that is at 0xFFFF while more transfers are still due, because the next step would wrap inside the page and not move on to the next page.

Top module: `dma_phys_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_be`, `out_wrap` and `out_addr` are all zero, and every page byte reads as zero.
- R2: For a request on a byte channel (0 to 3), `out_addr` equals {high page, low page, counter}, which gives 64K pages.
- R3: For a request on a word channel (5 to 7), `out_addr` equals {high page, low page bits 7:1, counter, 1'b0}. Low page bit 0 is ignored, address bit 0 is always zero, and the page size is 128K.
- R4: Word channels drive `out_be` = 2'b11. Byte channels drive exactly one enable: 2'b01 when address bit 0 is 0, and 2'b10 when it is 1.
- R5: A write to a channel's low page byte sets that channel's high page byte to zero.
- R6: A write to a channel's high page byte sets `out_addr[31:24]` for later requests on that channel and leaves the low page byte unchanged.
- R7: A request on channel 4 gives `out_valid` = 0, `out_be` = 0, `out_addr` = 0 and `out_wrap` = 0.
- R8: `out_wrap` is 1 only when a request on a data channel has counter 0xFFFF and `req_more` = 1. A counter of 0x0000 keeps the same page bits, so the address wraps inside the page.
- R9: Results appear on the outputs one clock after the request is sampled. On a cycle with no request, all outputs return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_wr_en | input | 1 | Page byte write strobe |
| pg_wr_hi | input | 1 | Write target: 1 = high page byte, 0 = low page byte |
| pg_wr_ch | input | 3 | Channel whose page byte is written |
| pg_wr_data | input | 8 | Page byte value |
| req_valid | input | 1 | An address request is present |
| req_ch | input | 3 | Channel of the request |
| req_cnt | input | 16 | Channel's current address counter |
| req_more | input | 1 | More transfers remain after this one |
| out_valid | output | 1 | A data channel address is present |
| out_addr | output | 32 | Physical byte address |
| out_be | output | 2 | Byte enables {upper, lower} |
| out_wrap | output | 1 | The counter would wrap inside the page |

## Verification
Every result is due exactly one clock edge after the request: the edge that samples `req_*` also loads the output registers. A page byte write changes the state at its own edge, so it affects a request sampled on any later edge. The bench changes inputs on falling edges and reads the outputs on the next falling edge after the sampling edge. This places each read half a period after the one register stage and away from the edge where the values change. Before it reads the outputs after a request, the bench returns `req_valid` low, and the next read confirms that the outputs have cleared.

// File: rtl/dma_phys_addr_gen.sv
module dma_phys_addr_gen #(
  parameter int NCH           = 8,
  parameter int CNT_W         = 16,
  parameter int PG_W          = 8,
  parameter int HI_W          = 8,
  parameter int CASCADE_CH    = 4,
  parameter int FIRST_WORD_CH = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pg_wr_en,
  input  logic                          pg_wr_hi,
  input  logic [$clog2(NCH)-1:0]        pg_wr_ch,
  input  logic [PG_W-1:0]               pg_wr_data,
  input  logic                          req_valid,
  input  logic [$clog2(NCH)-1:0]        req_ch,
  input  logic [CNT_W-1:0]              req_cnt,
  input  logic                          req_more,
  output logic                          out_valid,
  output logic [HI_W+PG_W+CNT_W-1:0]    out_addr,
  output logic [1:0]                    out_be,
  output logic                          out_wrap
);
  localparam int CH_W   = $clog2(NCH);
  localparam int ADDR_W = HI_W + PG_W + CNT_W;
  localparam logic [CH_W-1:0] CASC  = CH_W'(CASCADE_CH);
  localparam logic [CH_W-1:0] WBASE = CH_W'(FIRST_WORD_CH);

  logic [PG_W-1:0] lo_pg [NCH];
  logic [HI_W-1:0] hi_pg [NCH];

  wire             wr_ok   = pg_wr_en && (pg_wr_ch != CASC);
  wire             data_rq = req_valid && (req_ch != CASC);
  wire             is_word = req_ch >= WBASE;
  wire [PG_W-1:0]  cur_lo  = lo_pg[req_ch];
  wire [HI_W-1:0]  cur_hi  = hi_pg[req_ch];

  wire [ADDR_W-1:0] byte_addr = {cur_hi, cur_lo, req_cnt};
  wire [ADDR_W-1:0] word_addr = {cur_hi, cur_lo[PG_W-1:1], req_cnt, 1'b0};
  wire [1:0]        next_be   = is_word ? 2'b11 : (req_cnt[0] ? 2'b10 : 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        lo_pg[i] <= '0;
        hi_pg[i] <= '0;
      end
    end else if (wr_ok) begin
      if (pg_wr_hi) begin
        hi_pg[pg_wr_ch] <= HI_W'(pg_wr_data);
      end else begin
        lo_pg[pg_wr_ch] <= pg_wr_data;
        hi_pg[pg_wr_ch] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !data_rq) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_be    <= 2'b00;
      out_wrap  <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      out_addr  <= is_word ? word_addr : byte_addr;
      out_be    <= next_be;
      out_wrap  <= req_more && (&req_cnt);
    end
  end
endmodule

// File: rtl/dma_phys_addr_gen_chk.sv
module dma_phys_addr_gen_chk #(
  parameter int CH_W   = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CH_W-1:0]   req_ch,
  input logic [CNT_W-1:0]  req_cnt,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_be,
  input logic              out_wrap
);
  assert_word_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_ch) > CH_W'(4)) |-> (out_addr[0] == 1'b0));

  assert_word_both_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_ch) > CH_W'(4)) |-> (out_be == 2'b11));

  assert_byte_one_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_ch) < CH_W'(4)) |-> ($countones(out_be) == 1));

  assert_cascade_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ch == CH_W'(4)) |-> (!out_valid && out_be == 2'b00 && !out_wrap));

  assert_wrap_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_wrap |-> (out_valid && $past(req_cnt) == {CNT_W{1'b1}}));

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!out_valid && out_be == 2'b00 && out_addr == '0));
endmodule

bind dma_phys_addr_gen dma_phys_addr_gen_chk #(
  .CH_W($clog2(NCH)), .CNT_W(CNT_W), .ADDR_W(HI_W + PG_W + CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
  .req_cnt(req_cnt), .out_valid(out_valid), .out_addr(out_addr),
  .out_be(out_be), .out_wrap(out_wrap)
);

// File: tb/dma_phys_addr_gen_tb_top.sv
module dma_phys_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_wr_en = 1'b0, pg_wr_hi = 1'b0;
  logic [2:0]  pg_wr_ch = '0;
  logic [7:0]  pg_wr_data = '0;
  logic        req_valid = 1'b0, req_more = 1'b0;
  logic [2:0]  req_ch = '0;
  logic [15:0] req_cnt = '0;
  logic        out_valid, out_wrap;
  logic [31:0] out_addr;
  logic [1:0]  out_be;

  int n_chk = 0, n_fail = 0;
  logic        s_valid, s_wrap;
  logic [31:0] s_addr;
  logic [1:0]  s_be;

  always #5 clk = ~clk;

  dma_phys_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_wr_hi(pg_wr_hi),
    .pg_wr_ch(pg_wr_ch), .pg_wr_data(pg_wr_data), .req_valid(req_valid),
    .req_ch(req_ch), .req_cnt(req_cnt), .req_more(req_more),
    .out_valid(out_valid), .out_addr(out_addr), .out_be(out_be), .out_wrap(out_wrap)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_page(input logic [2:0] ch, input bit hi, input logic [7:0] d);
    @(negedge clk);
    pg_wr_en = 1'b1; pg_wr_hi = hi; pg_wr_ch = ch; pg_wr_data = d;
    @(negedge clk);
    pg_wr_en = 1'b0;
  endtask

  task automatic request(input logic [2:0] ch, input logic [15:0] cnt, input bit more);
    @(negedge clk);
    req_valid = 1'b1; req_ch = ch; req_cnt = cnt; req_more = more;
    @(negedge clk);
    s_valid = out_valid; s_addr = out_addr; s_be = out_be; s_wrap = out_wrap;
    req_valid = 1'b0; req_more = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_be == 0 && out_wrap == 0, "R1 flags in reset", {29'd0, out_valid, out_be}, 0);
    chk(out_addr == 0, "R1 addr in reset", out_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_addr == 0, "R1 after reset", out_addr, 0);
    request(3, 16'h00AB, 0);
    chk(s_addr == 32'h0000_00AB, "R1 page bytes zero", s_addr, 32'h0000_00AB);
  endtask

  task automatic t_byte;
    wr_page(1, 0, 8'h12);
    request(1, 16'h3457, 0);
    chk(s_addr == 32'h0012_3457, "R2 byte addr odd", s_addr, 32'h0012_3457);
    chk(s_be == 2'b10 && s_valid, "R4 byte odd be", {30'd0, s_be}, 2);
    request(1, 16'h3456, 0);
    chk(s_addr == 32'h0012_3456, "R2 byte addr even", s_addr, 32'h0012_3456);
    chk(s_be == 2'b01, "R4 byte even be", {30'd0, s_be}, 1);
  endtask

  task automatic t_word;
    wr_page(6, 0, 8'h35);
    request(6, 16'h1234, 0);
    chk(s_addr == 32'h0034_2468, "R3 word addr page bit0 ignored", s_addr, 32'h0034_2468);
    chk(s_be == 2'b11, "R4 word be", {30'd0, s_be}, 3);
    request(6, 16'h8001, 0);
    chk(s_addr == 32'h0035_0002, "R3 word counter msb to bit16", s_addr, 32'h0035_0002);
  endtask

  task automatic t_hipage;
    wr_page(6, 1, 8'hA5);
    request(6, 16'h1234, 0);
    chk(s_addr == 32'hA534_2468, "R6 high page bits", s_addr, 32'hA534_2468);
    wr_page(6, 0, 8'h35);
    request(6, 16'h1234, 0);
    chk(s_addr == 32'h0034_2468, "R5 low write clears high", s_addr, 32'h0034_2468);
    request(1, 16'h0000, 0);
    chk(s_addr == 32'h0012_0000, "R6 other channel untouched", s_addr, 32'h0012_0000);
  endtask

  task automatic t_cascade;
    request(4, 16'hFFFF, 1);
    chk(!s_valid && s_be == 0 && !s_wrap, "R7 cascade flags", {29'd0, s_valid, s_be}, 0);
    chk(s_addr == 0, "R7 cascade addr", s_addr, 0);
  endtask

  task automatic t_wrap;
    wr_page(2, 0, 8'h7F);
    wr_page(2, 1, 8'h01);
    request(2, 16'hFFFF, 1);
    chk(s_wrap && s_addr == 32'h017F_FFFF, "R8 byte wrap pending", s_addr, 32'h017F_FFFF);
    request(2, 16'hFFFF, 0);
    chk(!s_wrap, "R8 no wrap when last", {31'd0, s_wrap}, 0);
    request(2, 16'h0000, 1);
    chk(!s_wrap && s_addr == 32'h017F_0000, "R8 wraps inside page", s_addr, 32'h017F_0000);
    wr_page(7, 0, 8'h02);
    request(7, 16'hFFFF, 1);
    chk(s_wrap && s_addr == 32'h0003_FFFE, "R8 word wrap pending", s_addr, 32'h0003_FFFE);
  endtask

  task automatic t_idle;
    request(5, 16'h0101, 0);
    chk(s_valid, "R9 valid one cycle later", {31'd0, s_valid}, 1);
    @(negedge clk);
    chk(!out_valid && out_be == 0 && out_addr == 0, "R9 idle clears", out_addr, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_byte();
    t_word();
    t_hipage();
    t_cascade();
    t_wrap();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
    finish_run();
  end
endmodule